// File: doc/BRIEF.md
# Nine-bit addressed command broadcaster

This block sends one command byte to each of a fixed number of actuator nodes that share a single 9-bit serial link. The host loads all command bytes at once on a parallel bus and pulses a start strobe. The block then walks the nodes in ascending index order. For each node it emits two words. The first is an address word, with the ninth bit set and the node's address in the low byte. The second is a data word, with the ninth bit clear and that node's command byte in the low byte.

Each node's address is a base-address parameter plus the node's index. Receivers that watch the ninth bit can therefore wake on their own address and take only the byte that follows it. Words go to a 9-bit UART transmitter over a valid/ready handshake. The serializer itself is outside this block. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end.

Top module: `cbc_broadcaster`

## Requirements
- R1: After reset, busy_o, done_o and tx_valid_o are all low, and tx_valid_o stays low whenever the block is idle.
- R2: A start_i pulse while idle captures cmd_bytes_i. In the following cycle busy_o is high and tx_valid_o presents the first word.
- R3: An address word has tx_word_o[8] = 1 and tx_word_o[7:0] = (BASE_ADDR + node index) mod 256. Node k's command is cmd_bytes_i[8k+7:8k].
- R4: A data word has tx_word_o[8] = 0 and tx_word_o[7:0] equal to the command byte captured for that node at start.
- R5: Words leave in the order address 0, data 0, address 1, data 1, and so on up to the last node. Once an address word is accepted, the next cycle presents the matching data word.
- R6: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_word_o stays unchanged in the next cycle.
- R7: A start_i pulse while busy is ignored. Changes on cmd_bytes_i after capture have no effect on the words sent, and no second sequence follows.
- R8: In the cycle after the last data word is accepted, busy_o is low and done_o is high for exactly one cycle.
- R9: With tx_ready_i held high, one word is accepted every cycle. A new start_i while idle, right after done_o, begins a fresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| cmd_bytes_i | input | NODES*8 | Command bytes; node k in bits 8k+7:8k |
| busy_o | output | 1 | High while a sequence is in progress |
| done_o | output | 1 | One-cycle pulse after the final data word is accepted |
| tx_valid_o | output | 1 | Word to transmitter is valid |
| tx_ready_i | input | 1 | Transmitter accepts the word |
| tx_word_o | output | 9 | Bit 8 marks an address word; bits 7:0 hold the address or command |

## Verification
After a start pulse, busy and the first address word are due one clock later, because the state register is the only register in that path. Every accepted word is replaced at the next edge, and done is due one edge after the last data acceptance and gone one edge after that.

The bench drives its inputs and samples outputs at the falling edge. Each word is therefore checked in the half-cycle before the edge that accepts it. Done and busy are checked exactly one and two falling edges after the final acceptance.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = BYTE_W + 1;

    typedef struct packed {
        logic              mark;
        logic [BYTE_W-1:0] payload;
    } link_word_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_t;

    function automatic link_word_t addr_word(input logic [BYTE_W-1:0] base,
                                             input int unsigned idx);
        link_word_t w;
        w.mark    = 1'b1;
        w.payload = base + BYTE_W'(idx);
        return w;
    endfunction

    function automatic link_word_t data_word(input logic [BYTE_W-1:0] cmd);
        link_word_t w;
        w.mark    = 1'b0;
        w.payload = cmd;
        return w;
    endfunction

endpackage

// File: rtl/cbc_cmd_store.sv
module cbc_cmd_store
    import cbc_pkg::*;
#(
    parameter int NODES = 4,
    localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [NODES*BYTE_W-1:0] cmd_flat,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [BYTE_W-1:0]       rd_cmd
);

    logic [BYTE_W-1:0] slot_q [NODES];

    for (genvar g = 0; g < NODES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (load) begin
                slot_q[g] <= cmd_flat[g*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        rd_cmd = '0;
        for (int i = 0; i < NODES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_cmd = slot_q[i];
            end
        end
    end

endmodule

// File: rtl/cbc_sequencer.sv
module cbc_sequencer
    import cbc_pkg::*;
#(
    parameter int NODES = 4,
    localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             accept,
    output phase_t           phase,
    output logic [IDX_W-1:0] idx,
    output logic             load,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODES - 1);

    phase_t           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             done_q, done_d;

    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        done_d  = 1'b0;
        load    = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    idx_d   = '0;
                    phase_d = PH_ADDR;
                end
            end
            PH_ADDR: begin
                if (accept) begin
                    phase_d = PH_DATA;
                end
            end
            PH_DATA: begin
                if (accept) begin
                    if (idx_q == LAST_IDX) begin
                        phase_d = PH_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        phase_d = PH_ADDR;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
            done_q  <= done_d;
        end
    end

    assign phase = phase_q;
    assign idx   = idx_q;
    assign done  = done_q;

endmodule

// File: rtl/cbc_word_mux.sv
module cbc_word_mux
    import cbc_pkg::*;
#(
    parameter int               NODES     = 4,
    parameter logic [BYTE_W-1:0] BASE_ADDR = 8'h10,
    localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  phase_t            phase,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] cmd,
    output logic              valid,
    output link_word_t        word
);

    always_comb begin
        valid = 1'b0;
        word  = '0;
        unique case (phase)
            PH_ADDR: begin
                valid = 1'b1;
                word  = addr_word(BASE_ADDR, int'(idx));
            end
            PH_DATA: begin
                valid = 1'b1;
                word  = data_word(cmd);
            end
            default: begin
                valid = 1'b0;
                word  = '0;
            end
        endcase
    end

endmodule

// File: rtl/cbc_broadcaster.sv
module cbc_broadcaster
    import cbc_pkg::*;
#(
    parameter int               NODES     = 4,
    parameter logic [BYTE_W-1:0] BASE_ADDR = 8'h10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [NODES*BYTE_W-1:0] cmd_bytes_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    tx_valid_o,
    input  logic                    tx_ready_i,
    output logic [WORD_W-1:0]       tx_word_o
);

    localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1;

    phase_t            phase;
    logic [IDX_W-1:0]  idx;
    logic              load;
    logic [BYTE_W-1:0] cur_cmd;
    logic              valid;
    link_word_t        word;

    cbc_sequencer #(.NODES(NODES)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .accept (valid && tx_ready_i),
        .phase  (phase),
        .idx    (idx),
        .load   (load),
        .done   (done_o)
    );

    cbc_cmd_store #(.NODES(NODES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .cmd_flat (cmd_bytes_i),
        .rd_idx   (idx),
        .rd_cmd   (cur_cmd)
    );

    cbc_word_mux #(.NODES(NODES), .BASE_ADDR(BASE_ADDR)) u_mux (
        .phase (phase),
        .idx   (idx),
        .cmd   (cur_cmd),
        .valid (valid),
        .word  (word)
    );

    assign busy_o     = (phase != PH_IDLE);
    assign tx_valid_o = valid;
    assign tx_word_o  = word;

endmodule

// File: rtl/cbc_broadcaster_sva.sv
module cbc_broadcaster_sva (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       tx_valid_o,
    input logic       tx_ready_i,
    input logic [8:0] tx_word_o
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !tx_valid_o); // R1

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && tx_valid_o && tx_word_o[8])); // R2

    AST_DATA_FOLLOWS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && tx_ready_i && tx_word_o[8]) |=> (tx_valid_o && !tx_word_o[8])); // R5

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_word_o))); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(tx_valid_o && tx_ready_i && !tx_word_o[8]))); // R8

endmodule

bind cbc_broadcaster cbc_broadcaster_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_word_o  (tx_word_o)
);

// File: tb/test_cbc_broadcaster.sv
`timescale 1ns/1ps
module test_cbc_broadcaster;

    localparam int         NODES = 4;
    localparam logic [7:0] BASE  = 8'h10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start_i = 1'b0;
    logic [NODES*8-1:0] cmd_bytes_i = '0;
    logic               busy_o, done_o, tx_valid_o;
    logic               tx_ready_i = 1'b0;
    logic [8:0]         tx_word_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cbc_broadcaster #(.NODES(NODES), .BASE_ADDR(BASE)) i_cbc_broadcaster (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .cmd_bytes_i (cmd_bytes_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .tx_valid_o  (tx_valid_o),
        .tx_ready_i  (tx_ready_i),
        .tx_word_o   (tx_word_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one full sequence; stall inserts wait cycles, poke retries start mid-run
    task automatic run_seq(input logic [NODES*8-1:0] cmds, input bit stall, input bit poke);
        logic [8:0] exp;
        @(negedge clk);
        chk("R1 idle before start busy", busy_o, 0);
        start_i     = 1'b1;
        cmd_bytes_i = cmds;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 busy after start", busy_o, 1);
        chk("R2 valid after start", tx_valid_o, 1);
        for (int w = 0; w < 2*NODES; w++) begin
            int node = w / 2;
            exp = (w % 2 == 0) ? {1'b1, 8'(BASE + 8'(node))} : {1'b0, cmds[node*8 +: 8]};
            if (stall) begin
                for (int s = 0; s < (w % 3); s++) begin
                    tx_ready_i = 1'b0;
                    chk("R6 held valid", tx_valid_o, 1);
                    chk("R6 held word", tx_word_o, exp);
                    @(negedge clk);
                end
            end
            tx_ready_i = 1'b1;
            chk("R5 word order valid", tx_valid_o, 1);
            if (w % 2 == 0) chk("R3 address word", tx_word_o, exp);
            else            chk("R4 data word", tx_word_o, exp);
            if (poke && w == 3) begin
                start_i     = 1'b1;
                cmd_bytes_i = ~cmds;
            end
            @(negedge clk);
            start_i    = 1'b0;
            tx_ready_i = stall ? 1'b0 : 1'b1;
        end
        tx_ready_i = 1'b0;
        chk("R8 done pulse", done_o, 1);
        chk("R8 busy low at done", busy_o, 0);
        @(negedge clk);
        chk("R8 done one cycle", done_o, 0);
        chk("R7 no restart valid", tx_valid_o, 0);
        chk("R7 no restart busy", busy_o, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 reset busy", busy_o, 0);
        chk("R1 reset done", done_o, 0);
        chk("R1 reset valid", tx_valid_o, 0);
    endtask

    task automatic test_plain();
        run_seq(32'hA4_93_72_C5, 1'b0, 1'b0); // R9 full rate
    endtask

    task automatic test_stalled();
        run_seq(32'h01_FF_80_3C, 1'b1, 1'b0); // R6
    endtask

    task automatic test_ignored_start();
        run_seq(32'h5A_6B_7C_8D, 1'b1, 1'b1); // R7
    endtask

    task automatic test_back_to_back();
        run_seq(32'h11_22_33_44, 1'b0, 1'b0);
        run_seq(32'hEE_DD_CC_BB, 1'b0, 1'b0); // R9 restart right after done
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_plain();
        test_stalled();
        test_ignored_start();
        test_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule